// File: doc/BRIEF.md
# Delayed Branch Next-PC Sequencer

This block resolves the control-flow effect of a conditional branch in a pipeline that has one delay slot and an annul bit. For each branch presented with a valid strobe, it takes the branch's own address and the address of the instruction after it. It also takes a 4-bit condition code, the annul bit, the raw displacement field, a format select and the four integer condition flags. One cycle later it returns the next two fetch addresses and a flag that tells the pipeline to discard the delay-slot instruction.

Two branch formats are served. The short format uses a 19-bit displacement and the long format uses a 22-bit displacement. Both are word offsets from the branch's own address. The two unconditional encodings, always and never, are decoded ahead of the condition evaluator and have their own annul behaviour. Every other code is tested against the flags.

Top module: `dbs_next_pc`

## Requirements
- R1: Results are registered. `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. After reset all outputs are zero. While `in_valid` is low, `next_npc`, `next_nnpc` and `slot_annulled` keep their values.
- R2: The target is `pc` plus the sign-extended displacement shifted left by 2. With `fmt_long`=1 the displacement is `disp[21:0]`. With `fmt_long`=0 it is `disp[18:0]`, and bits 21:19 have no effect on any output.
- R3: Condition code 8 (always) with annul 0 gives `next_npc`=`npc`, `next_nnpc`=target and `slot_annulled`=0, whatever the flags.
- R4: Condition code 8 with annul 1 gives `next_npc`=target, `next_nnpc`=target+4 and `slot_annulled`=1, whatever the flags.
- R5: Condition code 0 (never) with annul 0 gives `next_npc`=`npc`, `next_nnpc`=`npc`+4 and `slot_annulled`=0, whatever the flags.
- R6: Condition code 0 with annul 1 gives `next_npc`=`npc`+4, `next_nnpc`=`npc`+8 and `slot_annulled`=1, whatever the flags.
- R7: Flags are packed as `icc[3]`=N, `icc[2]`=Z, `icc[1]`=V, `icc[0]`=C. Codes 1 to 7 test, in order: Z; Z or (N xor V); N xor V; C or Z; C; N; V. Codes 9 to 15 test the negation of codes 1 to 7 respectively.
- R8: For codes other than 0 and 8, a passing condition gives `next_npc`=`npc`, `next_nnpc`=target and `slot_annulled`=0, for either annul value.
- R9: For codes other than 0 and 8, a failing condition with annul 0 gives `npc`, `npc`+4 and no annul. A failing condition with annul 1 gives `npc`+4, `npc`+8 and `slot_annulled`=1.
- R10: All address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A branch is presented this cycle |
| fmt_long | input | 1 | 1 selects the 22-bit displacement, 0 the 19-bit one |
| pc | input | ADDR_W | Address of the branch |
| npc | input | ADDR_W | Address of the delay-slot instruction |
| cond | input | 4 | Condition code |
| annul | input | 1 | Annul bit of the branch |
| disp | input | 22 | Raw displacement field |
| icc | input | 4 | Integer flags N, Z, V, C (bits 3..0) |
| out_valid | output | 1 | Result registers updated last cycle |
| next_npc | output | ADDR_W | Next fetch address |
| next_nnpc | output | ADDR_W | Fetch address after that |
| slot_annulled | output | 1 | Delay-slot instruction is discarded |

## Verification
The bench builds the block with ADDR_W=32 and the default widths of 19 and 22 for the two displacements. The narrower address space lets random addresses near the top of memory reach the wraparound of R10. Directed passes sweep all sixteen condition codes against both annul values and both formats, with negative displacements and random flags. A short-format case sets the ignored upper displacement bits to show that they have no effect.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

   localparam logic [3:0] CC_NEVER  = 4'h0;
   localparam logic [3:0] CC_ALWAYS = 4'h8;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } icc_t;

   typedef enum logic [1:0] {
      ACT_SEQ       = 2'd0,
      ACT_TAKEN     = 2'd1,
      ACT_JUMP_SKIP = 2'd2,
      ACT_SEQ_SKIP  = 2'd3
   } act_t;

endpackage

// File: rtl/dbs_cond_eval.sv
module dbs_cond_eval
   import dbs_pkg::*;
(
   input  logic [3:0] cond,
   input  icc_t       flags,
   output logic       pass
);
   logic base;

   always_comb begin
      unique case (cond[2:0])
         3'd0: base = 1'b0;
         3'd1: base = flags.z;
         3'd2: base = flags.z | (flags.n ^ flags.v);
         3'd3: base = flags.n ^ flags.v;
         3'd4: base = flags.c | flags.z;
         3'd5: base = flags.c;
         3'd6: base = flags.n;
         default: base = flags.v;
      endcase
      pass = base ^ cond[3];
   end
endmodule

// File: rtl/dbs_disp_target.sv
module dbs_disp_target #(
   parameter int ADDR_W = 64,
   parameter int DISP_W = 22
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] target
);
   localparam int EXT_W = ADDR_W - DISP_W - 2;

   logic [ADDR_W-1:0] offset;

   assign offset = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
   assign target = pc + offset;
endmodule

// File: rtl/dbs_next_pc.sv
module dbs_next_pc
   import dbs_pkg::*;
#(
   parameter int ADDR_W       = 64,
   parameter int DISP_SHORT_W = 19,
   parameter int DISP_LONG_W  = 22
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   fmt_long,
   input  logic [ADDR_W-1:0]      pc,
   input  logic [ADDR_W-1:0]      npc,
   input  logic [3:0]             cond,
   input  logic                   annul,
   input  logic [DISP_LONG_W-1:0] disp,
   input  logic [3:0]             icc,
   output logic                   out_valid,
   output logic [ADDR_W-1:0]      next_npc,
   output logic [ADDR_W-1:0]      next_nnpc,
   output logic                   slot_annulled
);
   localparam int               N_FMT = 2;
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

   if (DISP_SHORT_W < 2 || DISP_SHORT_W >= DISP_LONG_W) begin : g_bad_short
      $error("dbs_next_pc: short displacement must be narrower than long");
   end
   if (DISP_LONG_W + 2 >= ADDR_W) begin : g_bad_addr
      $error("dbs_next_pc: address too narrow for displacement");
   end

   logic [ADDR_W-1:0] tgt [N_FMT];

   for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
      localparam int DW = (g == 1) ? DISP_LONG_W : DISP_SHORT_W;
      dbs_disp_target #(
         .ADDR_W (ADDR_W),
         .DISP_W (DW)
      ) u_tgt (
         .pc     (pc),
         .disp   (disp[DW-1:0]),
         .target (tgt[g])
      );
   end

   logic pass;

   dbs_cond_eval u_cond (
      .cond  (cond),
      .flags (icc_t'(icc)),
      .pass  (pass)
   );

   act_t              act;
   logic [ADDR_W-1:0] target, seq4, npc_d, nnpc_d;
   logic              ann_d;

   assign target = fmt_long ? tgt[1] : tgt[0];
   assign seq4   = npc + STEP;

   always_comb begin
      unique case (cond)
         CC_ALWAYS: act = annul ? ACT_JUMP_SKIP : ACT_TAKEN;
         CC_NEVER:  act = annul ? ACT_SEQ_SKIP  : ACT_SEQ;
         default:   act = pass ? ACT_TAKEN : (annul ? ACT_SEQ_SKIP : ACT_SEQ);
      endcase
   end

   always_comb begin
      unique case (act)
         ACT_TAKEN: begin
            npc_d = npc;    nnpc_d = target;        ann_d = 1'b0;
         end
         ACT_JUMP_SKIP: begin
            npc_d = target; nnpc_d = target + STEP; ann_d = 1'b1;
         end
         ACT_SEQ_SKIP: begin
            npc_d = seq4;   nnpc_d = seq4 + STEP;   ann_d = 1'b1;
         end
         default: begin
            npc_d = npc;    nnpc_d = seq4;          ann_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         next_npc      <= '0;
         next_nnpc     <= '0;
         slot_annulled <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            next_npc      <= npc_d;
            next_nnpc     <= nnpc_d;
            slot_annulled <= ann_d;
         end
      end
   end

   // R1: one-cycle latency of the valid strobe
   a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R1: results hold while idle
   a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(next_npc) && $stable(next_nnpc) && !out_valid));
   // R4, R6, R9: an annulled slot is always followed by a sequential pair
   a_r6_skip_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && slot_annulled) |-> (next_nnpc == next_npc + STEP));
   // R3, R5, R8: a kept delay slot means the delay-slot address passes through
   a_r8_keep_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !slot_annulled) |-> (next_npc == $past(npc)));
   // R5: branch-never without annul never annuls
   a_r5_never_plain: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cond == CC_NEVER && !annul) |=> !slot_annulled);

endmodule

// File: tb/sim_dbs_next_pc.sv
`timescale 1ns/1ps
module sim_dbs_next_pc;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          fmt_long = 1'b0;
   logic [AW-1:0] pc = '0;
   logic [AW-1:0] npc = '0;
   logic [3:0]    cond = '0;
   logic          annul = 1'b0;
   logic [21:0]   disp = '0;
   logic [3:0]    icc = '0;
   logic          out_valid;
   logic [AW-1:0] next_npc, next_nnpc;
   logic          slot_annulled;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   dbs_next_pc #(.ADDR_W(AW), .DISP_SHORT_W(19), .DISP_LONG_W(22)) u0 (
      .clk, .rst_n, .in_valid, .fmt_long, .pc, .npc, .cond, .annul,
      .disp, .icc, .out_valid, .next_npc, .next_nnpc, .slot_annulled
   );

   function automatic bit cond_ok(input logic [3:0] c, input logic [3:0] f);
      bit n, z, v, cf;
      n = f[3]; z = f[2]; v = f[1]; cf = f[0];
      case (c)
         4'd0:  return 0;
         4'd8:  return 1;
         4'd1:  return z;
         4'd9:  return !z;
         4'd2:  return z || (n != v);
         4'd10: return !(z || (n != v));
         4'd3:  return n != v;
         4'd11: return n == v;
         4'd4:  return cf || z;
         4'd12: return !(cf || z);
         4'd5:  return cf;
         4'd13: return !cf;
         4'd6:  return n;
         4'd14: return !n;
         4'd7:  return v;
         default: return !v;
      endcase
   endfunction

   function automatic logic [AW-1:0] tgt_of(input logic [AW-1:0] p,
                                             input logic [21:0] d,
                                             input logic fl);
      logic signed [AW-1:0] off;
      if (fl) off = AW'($signed(d)) <<< 2;
      else    off = AW'($signed(d[18:0])) <<< 2;
      return p + off;
   endfunction

   function automatic string tag_of(input logic [3:0] c, input logic a);
      if (c == 4'd8) return a ? "R4" : "R3";
      if (c == 4'd0) return a ? "R6" : "R5";
      return "R7/R8/R9";
   endfunction

   task automatic expect3(input string tag, input logic [AW-1:0] en,
                          input logic [AW-1:0] enn, input logic ea);
      checks++;
      if (out_valid !== 1'b1 || next_npc !== en || next_nnpc !== enn ||
          slot_annulled !== ea) begin
         errors++;
         $display("FAIL %s: got v=%0b npc=%h nnpc=%h ann=%0b, expected v=1 npc=%h nnpc=%h ann=%0b",
                  tag, out_valid, next_npc, next_nnpc, slot_annulled, en, enn, ea);
      end
   endtask

   task automatic run_one(input logic [AW-1:0] p, input logic [3:0] c,
                          input logic a, input logic [21:0] d,
                          input logic fl, input logic [3:0] f,
                          input string tag_in);
      logic [AW-1:0] t, en, enn;
      logic ea;
      string tag;
      tag = (tag_in == "") ? tag_of(c, a) : tag_in;
      t = tgt_of(p, d, fl);
      if (c == 4'd8) begin
         if (a) begin en = t; enn = t + 4; ea = 1; end
         else   begin en = p + 4; enn = t; ea = 0; end
      end else if (c != 4'd0 && cond_ok(c, f)) begin
         en = p + 4; enn = t; ea = 0;
      end else if (a) begin
         en = p + 8; enn = p + 12; ea = 1;
      end else begin
         en = p + 4; enn = p + 8; ea = 0;
      end
      @(negedge clk);
      in_valid = 1; pc = p; npc = p + 4; cond = c; annul = a;
      disp = d; fmt_long = fl; icc = f;
      @(negedge clk);
      in_valid = 0;
      expect3(tag, en, enn, ea);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (out_valid !== 0 || next_npc !== '0 || next_nnpc !== '0 || slot_annulled !== 0) begin
         errors++;
         $display("FAIL R1: got reset outputs v=%0b npc=%h nnpc=%h ann=%0b, expected all zero",
                  out_valid, next_npc, next_nnpc, slot_annulled);
      end
      rst_n = 1;

      // Directed sweep: every code, annul and format, negative displacement
      for (int c = 0; c < 16; c++)
         for (int a = 0; a < 2; a++)
            for (int fl = 0; fl < 2; fl++)
               run_one(32'h0040_1000, 4'(c), 1'(a),
                       fl ? 22'h3FFFF0 : 22'h07FFF0, 1'(fl),
                       4'($urandom_range(15)), "");

      // R7: every code against every flag pattern
      for (int c = 1; c < 16; c++)
         for (int f = 0; f < 16; f++)
            if (c != 8) run_one(32'h0000_8000, 4'(c), 1'b1, 22'h000010, 1'b1, 4'(f), "R7");

      // R2: upper bits of short field ignored
      run_one(32'h0010_0000, 4'd8, 1'b1, 22'h380005, 1'b0, 4'h0, "R2");
      run_one(32'h0010_0000, 4'd8, 1'b1, 22'h040000, 1'b0, 4'h0, "R2");
      run_one(32'h0010_0000, 4'd8, 1'b1, 22'h200000, 1'b1, 4'h0, "R2");

      // R10: wraparound at the top and bottom of the address space
      run_one(32'hFFFF_FFF8, 4'd8, 1'b1, 22'h000004, 1'b1, 4'h0, "R10");
      run_one(32'hFFFF_FFF4, 4'd0, 1'b1, 22'h000000, 1'b0, 4'h0, "R10");
      run_one(32'h0000_0004, 4'd8, 1'b0, 22'h3FFFFC, 1'b1, 4'h0, "R10");

      // R1: outputs hold while idle
      begin
         logic [AW-1:0] hn, hnn;
         logic ha;
         hn = next_npc; hnn = next_nnpc; ha = slot_annulled;
         repeat (3) @(negedge clk);
         checks++;
         if (out_valid !== 0 || next_npc !== hn || next_nnpc !== hnn || slot_annulled !== ha) begin
            errors++;
            $display("FAIL R1: got v=%0b npc=%h nnpc=%h ann=%0b while idle, expected v=0 npc=%h nnpc=%h ann=%0b",
                     out_valid, next_npc, next_nnpc, slot_annulled, hn, hnn, ha);
         end
      end

      // Constrained random mix
      for (int i = 0; i < 3000; i++) begin
         logic [AW-1:0] p;
         p = {$urandom()} & ~32'h3;
         run_one(p, 4'($urandom_range(15)), 1'($urandom_range(1)),
                 22'($urandom()), 1'($urandom_range(1)),
                 4'($urandom_range(15)), "");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule